// File: doc/BRIEF.md
# Chainable Bit-Serial Boot Memory Reader

This block is the read path of a bit-serial memory that supplies a configuration bitstream to a programmable logic device while that device boots. Each rising clock edge advances an internal word address and bit index, and the selected stored bit appears on a three-state data pin. The memory contents are a parameter image, so the readout logic itself holds no writable storage.

Several copies can be chained to form one continuous stream. The chip-enable-out of one device drives the chip-enable of the next. When a device has shifted out its final bit, it releases the shared data net and lowers its chip-enable-out, and the next device begins driving in that same cycle. A reset/output-enable input rewinds the counters. Its polarity is a parameter. A serial-enable input parks the device in programming mode. An open-drain ready pin stays low for a fixed number of clocks after the system reset is removed.

Top module: `cfg_serial_rom`

## Requirements
- R1: After rst_n is released, READY is driven low for exactly POR_CYCLES rising edges and is then left undriven (high impedance). Until READY is released, DATA is never driven.
- R2: With serial-enable high, chip-enable low and reset/OE inactive, DATA is driven and shows one stored bit per cycle. Each rising edge advances to the next bit. Words are read from address 0 upward, most significant bit first, so stream bit n is IMAGE[(n/WORD_W)*WORD_W + WORD_W-1 - n%WORD_W].
- R3: While reset/OE is active, DATA is undriven. At each rising edge the word and bit counters and the end-of-memory state are cleared, whatever the state of chip-enable. The next read therefore starts at stream bit 0.
- R4: While chip-enable is high, DATA is undriven and the counters hold. When chip-enable returns low, reading resumes at the bit that was pending.
- R5: In the cycle after the last stored bit is read, DATA is no longer driven and chip-enable-out is low. The counters do not wrap, and further edges drive nothing.
- R6: Once the memory has been exhausted, chip-enable-out equals chip-enable while reset/OE is inactive. When reset/OE goes active, chip-enable-out goes high, and it stays high until the whole memory has been read again.
- R7: While serial-enable is low, DATA is undriven and the counters hold whatever chip-enable does. Reading resumes at the pending bit when serial-enable returns high.
- R8: The parameter RST_ACTIVE_HIGH selects the level of reset/OE that counts as active. With 1 (the default), a high level rewinds; with 0, a low level rewinds and a high level enables output.
- R9: In a two-device chain with the first device's chip-enable-out wired to the second's chip-enable, the shared DATA net carries the first image and then the second without a gap cycle, and the two devices never drive it at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial read clock; counters advance on the rising edge |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously |
| ser_en | input | 1 | High for read operation, low for programming mode |
| ce_n | input | 1 | Active-low chip enable (from the previous device's chip-enable-out) |
| rst_oe | input | 1 | Reset/output-enable; active level set by RST_ACTIVE_HIGH |
| data | output | 1 | Three-state serial data output |
| data_oe | output | 1 | High in every cycle in which data is driven |
| ceo_n | output | 1 | Active-low chip-enable-out toward the next device |
| ready | output | 1 | Open-drain power-on indicator: low or high impedance |

## Verification
All outputs are combinational decodes of registered counters and the current inputs. A new input level therefore shows up in the same cycle, and a counter effect shows up after one rising edge. Stream bit n is visible in the cycle after the n-th rising edge of a read. Chip-enable-out falls one edge after the last bit, and READY is released after the POR_CYCLES-th edge following reset removal. The bench changes inputs on the falling edge and samples one time unit later. The scoreboard monitor samples two units after the falling edge. Every expectation is therefore compared in the cycle in which it is due.

// File: rtl/cfg_rom_pkg.sv
package cfg_rom_pkg;

  typedef enum logic [1:0] {
    ACC_HOLD  = 2'd0,
    ACC_IDLE  = 2'd1,
    ACC_CLEAR = 2'd2,
    ACC_READ  = 2'd3
  } acc_mode_e;

  // Priority: programming mode / power-on wait, then rewind, then standby.
  function automatic acc_mode_e decode_mode(input logic ser_en,
                                            input logic ce_n,
                                            input logic oe_act,
                                            input logic por_done);
    if (!ser_en || !por_done) return ACC_HOLD;
    if (oe_act)               return ACC_CLEAR;
    if (ce_n)                 return ACC_IDLE;
    return ACC_READ;
  endfunction

endpackage

// File: rtl/cfg_rom_por.sv
module cfg_rom_por #(
  parameter int POR_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic por_done
);
  localparam int CW = $clog2(POR_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign por_done = (cnt_q == CW'(POR_CYCLES));
  assign cnt_en   = !por_done;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cfg_rom_seq.sv
module cfg_rom_seq
  import cfg_rom_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int WORD_W = 8,
  localparam int AW    = $clog2(WORDS),
  localparam int BW    = $clog2(WORD_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  acc_mode_e     mode,
  output logic [AW-1:0] word_q,
  output logic [BW-1:0] bit_q,
  output logic          done_q
);
  logic [AW-1:0] word_d;
  logic [BW-1:0] bit_d;
  logic          done_d;
  logic          adv_en;
  logic          last_bit;
  logic          last_word;

  assign adv_en    = (mode == ACC_READ) && !done_q;
  assign last_bit  = (bit_q == BW'(WORD_W - 1));
  assign last_word = (word_q == AW'(WORDS - 1));

  always_comb begin
    word_d = word_q;
    bit_d  = bit_q;
    done_d = done_q;
    if (mode == ACC_CLEAR) begin
      word_d = '0;
      bit_d  = '0;
      done_d = 1'b0;
    end else if (adv_en) begin
      if (!last_bit) begin
        bit_d = bit_q + BW'(1);
      end else if (last_word) begin
        done_d = 1'b1;
      end else begin
        bit_d  = '0;
        word_d = word_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      word_q <= word_d;
      bit_q  <= bit_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/cfg_rom_array.sv
module cfg_rom_array #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 8,
  parameter logic [WORDS*WORD_W-1:0] IMAGE = '0,
  localparam int AW    = $clog2(WORDS),
  localparam int BW    = $clog2(WORD_W)
) (
  input  logic [AW-1:0] word_i,
  input  logic [BW-1:0] bit_i,
  output logic          bit_o
);
  logic [WORD_W-1:0] words [WORDS];
  logic [WORD_W-1:0] cur;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    assign words[g] = IMAGE[g*WORD_W +: WORD_W];
  end

  assign cur   = words[word_i];
  assign bit_o = cur[BW'(WORD_W - 1) - bit_i];
endmodule

// File: rtl/cfg_serial_rom.sv
module cfg_serial_rom
  import cfg_rom_pkg::*;
#(
  parameter int WORDS           = 8,
  parameter int WORD_W          = 8,
  parameter int POR_CYCLES      = 16,
  parameter bit RST_ACTIVE_HIGH = 1'b1,
  parameter logic [WORDS*WORD_W-1:0] IMAGE = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_en,
  input  logic ce_n,
  input  logic rst_oe,
  output logic data,
  output logic data_oe,
  output logic ceo_n,
  output logic ready
);
  localparam int AW = $clog2(WORDS);
  localparam int BW = $clog2(WORD_W);

  logic          oe_act;
  logic          por_done;
  acc_mode_e     mode;
  logic [AW-1:0] word_q;
  logic [BW-1:0] bit_q;
  logic          done_q;
  logic          bit_val;

  if (RST_ACTIVE_HIGH) begin : g_rst_hi
    assign oe_act = rst_oe;
  end else begin : g_rst_lo
    assign oe_act = ~rst_oe;
  end

  cfg_rom_por #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk      (clk),
    .rst_n    (rst_n),
    .por_done (por_done)
  );

  assign mode = decode_mode(ser_en, ce_n, oe_act, por_done);

  cfg_rom_seq #(.WORDS(WORDS), .WORD_W(WORD_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode),
    .word_q (word_q),
    .bit_q  (bit_q),
    .done_q (done_q)
  );

  cfg_rom_array #(.WORDS(WORDS), .WORD_W(WORD_W), .IMAGE(IMAGE)) u_array (
    .word_i (word_q),
    .bit_i  (bit_q),
    .bit_o  (bit_val)
  );

  assign data_oe = (mode == ACC_READ) && !done_q;
  assign data    = data_oe ? bit_val : 1'bz;
  assign ceo_n   = !(done_q && !oe_act && !ce_n);
  assign ready   = por_done ? 1'bz : 1'b0;
endmodule

// File: rtl/cfg_serial_rom_chk.sv
module cfg_serial_rom_chk #(
  parameter int AW = 3,
  parameter int BW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ser_en,
  input logic          ce_n,
  input logic          oe_act,
  input logic          por_done,
  input logic          data_oe,
  input logic          ceo_n,
  input logic          done_q,
  input logic [AW-1:0] word_q,
  input logic [BW-1:0] bit_q
);
  p_por_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !por_done |-> !data_oe);

  p_drive_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (ser_en && !ce_n && !oe_act));

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |=> (!$stable({word_q, bit_q}) || done_q));

  p_rewind_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && por_done && oe_act) |=> (word_q == '0 && bit_q == '0 && !done_q));

  p_standby_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && ce_n && !oe_act) |=> $stable({word_q, bit_q, done_q}));

  p_end_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !data_oe);

  p_ceo_rewind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_act |-> ceo_n);

  p_ceo_unread_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> ceo_n);

  p_prog_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |-> !data_oe);

  p_prog_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |=> $stable({word_q, bit_q, done_q}));
endmodule

bind cfg_serial_rom cfg_serial_rom_chk #(.AW(AW), .BW(BW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ser_en   (ser_en),
  .ce_n     (ce_n),
  .oe_act   (oe_act),
  .por_done (por_done),
  .data_oe  (data_oe),
  .ceo_n    (ceo_n),
  .done_q   (done_q),
  .word_q   (word_q),
  .bit_q    (bit_q)
);

// File: tb/cfg_serial_rom_tb.sv
module cfg_serial_rom_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 8;
  localparam int WORD_W     = 8;
  localparam int NBITS      = WORDS * WORD_W;
  localparam int POR        = 16;
  localparam logic [NBITS-1:0] IMG_A = 64'hA5C3_0F96_3C5A_E718;
  localparam logic [NBITS-1:0] IMG_B = 64'h1E2D_3C4B_5A69_7887;

  logic clk, rst_n, ser_en, ce_a, oe, pol_oe_n;
  wire  chain_data, ready_net, pol_data, ready_pol;
  logic oe_a, oe_b, oe_p, ceo_a, ceo_b, ceo_p;
  pullup (ready_net);
  pullup (ready_pol);

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit sb_on = 0;
  int popped = 0;
  logic exp_q[$];

  cfg_serial_rom #(.WORDS(WORDS), .WORD_W(WORD_W), .POR_CYCLES(POR), .IMAGE(IMG_A)) u_dut (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ce_n(ce_a), .rst_oe(oe),
    .data(chain_data), .data_oe(oe_a), .ceo_n(ceo_a), .ready(ready_net));

  cfg_serial_rom #(.WORDS(WORDS), .WORD_W(WORD_W), .POR_CYCLES(POR), .IMAGE(IMG_B)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ce_n(ceo_a), .rst_oe(oe),
    .data(chain_data), .data_oe(oe_b), .ceo_n(ceo_b), .ready(ready_net));

  cfg_serial_rom #(.WORDS(WORDS), .WORD_W(WORD_W), .POR_CYCLES(POR),
                   .RST_ACTIVE_HIGH(1'b0), .IMAGE(IMG_A)) u_pol (
    .clk(clk), .rst_n(rst_n), .ser_en(1'b1), .ce_n(1'b0), .rst_oe(pol_oe_n),
    .data(pol_data), .data_oe(oe_p), .ceo_n(ceo_p), .ready(ready_pol));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_bit(input logic [NBITS-1:0] img, input int n);
    return img[(n / WORD_W) * WORD_W + WORD_W - 1 - (n % WORD_W)];
  endfunction

  task automatic chk(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // driver side of the scoreboard: queue both images as one stream
  task automatic push_chain();
    for (int n = 0; n < NBITS; n++) exp_q.push_back(exp_bit(IMG_A, n));
    for (int n = 0; n < NBITS; n++) exp_q.push_back(exp_bit(IMG_B, n));
  endtask

  // monitor side: pop one item per driven cycle
  always @(negedge clk) begin
    #2;
    if (sb_on) begin
      if (oe_a && oe_b) chk("R9 overlap on shared net", 1, 0);
      if (oe_a || oe_b) begin
        if (exp_q.size() == 0) chk("R9 extra driven bit", 1, 0);
        else begin
          chk("R9 stream bit", int'(chain_data), int'(exp_q.pop_front()));
          popped++;
        end
      end
    end
  end

  initial begin
    repeat (3000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 0; ser_en = 1; ce_a = 0; oe = 0; pol_oe_n = 0;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 reset ready low", int'(ready_net), 0);
    chk("R1 reset no drive", int'(oe_a), 0);
    @(negedge clk);
    rst_n = 1;
    repeat (POR - 1) @(negedge clk);
    #1;
    chk("R1 ready still low", int'(ready_net), 0);
    chk("R1 no drive during por", int'(oe_a), 0);
    @(negedge clk); #1;
    chk("R1 ready released", int'(ready_net), 1);
    chk("R1 pol ready released", int'(ready_pol), 1);
    // R2 stream bits 0..2
    for (int n = 0; n < 3; n++) begin
      if (n > 0) begin @(negedge clk); #1; end
      chk("R2 drive", int'(oe_a), 1);
      chk("R2 bit", int'(chain_data), int'(exp_bit(IMG_A, n)));
    end
    // R4 standby holds position
    @(negedge clk); ce_a = 1; #1;
    chk("R4 standby no drive", int'(oe_a), 0);
    repeat (3) @(negedge clk);
    ce_a = 0; #1;
    chk("R4 resume drive", int'(oe_a), 1);
    chk("R4 resume bit3", int'(chain_data), int'(exp_bit(IMG_A, 3)));
    // R7 programming mode
    @(negedge clk); ser_en = 0; #1;
    chk("R7 prog no drive", int'(oe_a), 0);
    repeat (3) @(negedge clk);
    #1;
    chk("R7 prog ce low no drive", int'(oe_a), 0);
    @(negedge clk); ser_en = 1; #1;
    chk("R7 resume bit4", int'(chain_data), int'(exp_bit(IMG_A, 4)));
    // R3 rewind
    @(negedge clk); oe = 1; #1;
    chk("R3 rewind no drive", int'(oe_a), 0);
    @(negedge clk); oe = 0; #1;
    chk("R3 restart bit0", int'(chain_data), int'(exp_bit(IMG_A, 0)));
    chk("R3 restart drive", int'(oe_a), 1);
    // R9 chain run
    @(negedge clk); oe = 1;
    @(negedge clk);
    push_chain();
    oe = 0; sb_on = 1;
    for (int n = 0; n < 2*NBITS + 3; n++) begin
      #1;
      if (n == NBITS) begin
        chk("R5 first ceo low", int'(ceo_a), 0);
        chk("R5 first released", int'(oe_a), 0);
        chk("R9 second takes over", int'(oe_b), 1);
      end
      if (n == 2*NBITS + 1) begin
        chk("R5 second ceo low", int'(ceo_b), 0);
        chk("R5 no wrap", int'(oe_a | oe_b), 0);
      end
      @(negedge clk);
    end
    sb_on = 0;
    chk("R9 all bits seen", popped, 2*NBITS);
    // R6 chip-enable-out rules after exhaustion
    ce_a = 1; #1;
    chk("R6 ceo follows ce high", int'(ceo_a), 1);
    chk("R6 chained ceo follows", int'(ceo_b), 1);
    @(negedge clk); ce_a = 0; #1;
    chk("R6 ceo follows ce low", int'(ceo_a), 0);
    @(negedge clk); oe = 1; #1;
    chk("R6 ceo high on rewind", int'(ceo_a), 1);
    @(negedge clk); oe = 0; #1;
    chk("R6 ceo stays high", int'(ceo_a), 1);
    chk("R6 read again bit0", int'(chain_data), int'(exp_bit(IMG_A, 0)));
    // R8 active-low reset/OE variant
    chk("R8 low level rewinds", int'(oe_p), 0);
    @(negedge clk); pol_oe_n = 1; #1;
    chk("R8 high enables", int'(oe_p), 1);
    chk("R8 bit0", int'(pol_data), int'(exp_bit(IMG_A, 0)));
    @(negedge clk); #1;
    chk("R8 bit1", int'(pol_data), int'(exp_bit(IMG_A, 1)));
    @(negedge clk); pol_oe_n = 0; #1;
    chk("R8 low stops drive", int'(oe_p), 0);
    @(negedge clk); pol_oe_n = 1; #1;
    chk("R8 restart bit0", int'(pol_data), int'(exp_bit(IMG_A, 0)));
    finish_run();
  end
endmodule